// File: doc/BRIEF.md
# Queued-Command I2C Master Engine

This block is an I2C/SMBus bus master whose every bus action comes from a queue of command words. Software pushes 11-bit commands into a transmit queue. A command either opens a transfer with a START and an address byte, sends one data byte, or clocks in a given number of bytes. Any command can also ask for a STOP once its bus work is done. Received bytes are placed in a receive queue, and software pops them through a register that also flags an empty queue.

The engine produces SCL and SDA through open-drain style enables: a high enable pulls the line low. It samples SDA through one input. A NACK from the addressed device sets a sticky flag and closes the bus with a STOP. The rest of the failed message is then thrown away from the queue, so that the next message starts cleanly. A completion flag reports each closed transfer. Both flags clear when a 1 is written to them. A control register holds the enable, two queue-flush strobes and the SCL divider.

Register map (2-bit word address): 0 pushes a command, 1 pops a received byte, 2 holds the status and 3 holds the control.

Top module: `cmdq_i2c_master`

## Requirements
- R1: A command word with bit 8 set issues a START (repeated START if the bus is held) and then sends bits [7:0] as the address byte. A word with bits 8 and 10 clear sends bits [7:0] as a data byte. A word with bit 9 set is followed by a STOP after its byte's acknowledge slot. SDA changes while SCL is high only for START and STOP.
- R2: A START word that follows a word without STOP produces a repeated START, and no STOP comes between them.
- R3: A word with bit 10 set (and bit 8 clear) clocks in bits [7:0] bytes, most significant bit first. The master acknowledges every byte except the last one, which it does not acknowledge. Each byte is pushed into the receive queue.
- R4: A read of address 1 returns the oldest received byte in bits [7:0], with bit 8 clear. When the queue is empty, bit 8 is set and bits [7:0] read as zero.
- R5: Status bit 27 (completion) and bit 21 (NACK) are sticky and read back at those positions. Writing a 1 to a bit clears it. Writing a 0 leaves it unchanged.
- R6: When a written byte is not acknowledged, the engine sets the NACK flag and issues a STOP. It then discards queued words up to and including the next word with bit 9 set, or until the queue is empty, and then sets the completion flag. Later words run normally.
- R7: While control bit 11 is clear, no queued command starts.
- R8: Writing control with bit 9 set empties the command queue, and writing it with bit 10 set empties the receive queue.
- R9: Within a byte, consecutive SCL rising edges are 4×(D+1) clock cycles apart, where D is control bits [7:0].
- R10: Each queue holds 16 entries. Commands pushed while the command queue is full are dropped. Bytes received while the receive queue is full are lost.
- R11: After reset both line enables are low, status reads 0, control reads 0 and the receive queue reads empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_oe | output | 1 | Pull SDA low when high |
| sda_i | input | 1 | Sampled SDA line level |

## Verification
A write message and a sweep of read lengths from one to four bytes are run against a bus-level device model. The read sweep shows whether the master withholds the acknowledge on exactly the final byte and stores bytes in order. A write followed by a START read tells a repeated START apart from a STOP followed by a new START. A device that refuses the first data byte, with a second message queued behind it, shows whether the discard stops at the right word. Queue overflow of both queues and a sweep of four divider values check the depth limits and the SCL period.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } bus_op_e;

  typedef enum logic [1:0] {
    RA_TX   = 2'd0,
    RA_RX   = 2'd1,
    RA_STAT = 2'd2,
    RA_CTRL = 2'd3
  } reg_addr_e;

  // command word: read flag, stop flag, start flag, value byte
  typedef struct packed {
    logic       rd;
    logic       stop;
    logic       start;
    logic [7:0] val;
  } cmd_t;

  localparam int CMD_W         = 11;
  localparam int STAT_DONE_BIT = 27;
  localparam int STAT_NACK_BIT = 21;
  localparam int CTL_TXCLR_BIT = 9;
  localparam int CTL_RXCLR_BIT = 10;
  localparam int CTL_EN_BIT    = 11;
  localparam int RX_EMPTY_BIT  = 8;

endpackage

// File: rtl/i2cq_fifo.sv
module i2cq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   level;
  logic          push_ok, pop_ok;

  assign full    = (level == (AW+1)'(DEPTH));
  assign empty   = (level == '0);
  assign push_ok = push && !full && !clr;
  assign pop_ok  = pop && !empty && !clr;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (pop_ok) rdata <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (push_ok) wptr <= wptr + 1'b1;
      if (pop_ok)  rptr <= rptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  // R10
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !clr) |=> (level == $past(level)));

endmodule

// File: rtl/i2cq_bitctl.sv
module i2cq_bitctl
  import i2cq_pkg::*;
#(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [DIVW-1:0] div,
  input  logic            go,
  input  bus_op_e         op,
  input  logic [7:0]      wbyte,
  input  logic            ack_en,
  input  logic            sda_i,
  output logic            done,
  output logic [7:0]      rbyte,
  output logic            acked,
  output logic            scl_oe,
  output logic            sda_oe
);
  localparam logic [DIVW-1:0] ONE = DIVW'(1);

  logic            busy;
  logic [DIVW-1:0] dcnt, div_q;
  logic [1:0]      q;
  logic [3:0]      slot;
  logic [7:0]      sh;
  bus_op_e         op_q;
  logic            ack_q;
  logic            tick;
  logic [2:0]      bidx;

  assign tick  = busy && (dcnt == div_q);
  assign bidx  = 3'd7 - slot[2:0];
  assign rbyte = sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      dcnt   <= '0;
      div_q  <= '0;
      q      <= '0;
      slot   <= '0;
      sh     <= '0;
      op_q   <= OP_STOP;
      ack_q  <= 1'b0;
      acked  <= 1'b0;
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (go) begin
          busy  <= 1'b1;
          op_q  <= op;
          sh    <= wbyte;
          ack_q <= ack_en;
          div_q <= div;
          dcnt  <= '0;
          q     <= '0;
          slot  <= '0;
        end
      end else if (!tick) begin
        dcnt <= dcnt + ONE;
      end else begin
        dcnt <= '0;
        q    <= q + 2'd1;
        unique case (op_q)
          OP_START: begin
            case (q)
              2'd0:    sda_oe <= 1'b0;
              2'd1:    scl_oe <= 1'b0;
              2'd2:    sda_oe <= 1'b1;
              default: scl_oe <= 1'b1;
            endcase
          end
          OP_STOP: begin
            case (q)
              2'd0:    sda_oe <= 1'b1;
              2'd1:    scl_oe <= 1'b0;
              2'd2:    sda_oe <= 1'b0;
              default: ;
            endcase
          end
          OP_WRITE, OP_READ: begin
            case (q)
              2'd0: begin
                scl_oe <= 1'b1;
                if (slot == 4'd8) sda_oe <= (op_q == OP_READ) && ack_q;
                else              sda_oe <= (op_q == OP_WRITE) && !sh[bidx];
              end
              2'd1: scl_oe <= 1'b0;
              2'd2: begin
                if (slot == 4'd8)          acked <= !sda_i;
                else if (op_q == OP_READ)  sh    <= {sh[6:0], sda_i};
              end
              default: scl_oe <= 1'b1;
            endcase
          end
        endcase
        if (q == 2'd3) begin
          if (op_q == OP_START || op_q == OP_STOP || slot == 4'd8) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            slot <= slot + 4'd1;
          end
        end
      end
    end
  end

  // R1
  sda_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (!scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe)))
      |-> (op_q == OP_START || op_q == OP_STOP));

  // R9
  div_window_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (dcnt <= div_q));

endmodule

// File: rtl/i2cq_seq.sv
module i2cq_seq
  import i2cq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       tx_empty,
  input  cmd_t       tx_cmd,
  output logic       tx_pop,
  output logic       eng_go,
  output bus_op_e    eng_op,
  output logic [7:0] eng_byte,
  output logic       eng_ack,
  input  logic       eng_done,
  input  logic       eng_acked,
  output logic       rx_push,
  output logic       set_done,
  output logic       set_nack
);
  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_ADDR, S_WR, S_RD, S_STOP, S_NSTOP, S_FLUSH, S_FLCHK
  } seq_st_e;

  seq_st_e    st;
  cmd_t       cmd_q;
  logic [7:0] cnt;

  assign tx_pop   = (st == S_IDLE && en && !tx_empty) || (st == S_FLUSH && !tx_empty);
  assign rx_push  = (st == S_RD) && eng_done;
  assign set_nack = (st == S_WR) && eng_done && !eng_acked;
  assign set_done = ((st == S_STOP) && eng_done)
                 || ((st == S_NSTOP) && eng_done && cmd_q.stop)
                 || ((st == S_FLUSH) && tx_empty)
                 || ((st == S_FLCHK) && tx_cmd.stop);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      cmd_q    <= '0;
      cnt      <= '0;
      eng_go   <= 1'b0;
      eng_op   <= OP_STOP;
      eng_byte <= '0;
      eng_ack  <= 1'b0;
    end else begin
      eng_go <= 1'b0;
      unique case (st)
        S_IDLE: if (tx_pop) st <= S_FETCH;
        S_FETCH: begin
          cmd_q <= tx_cmd;
          if (tx_cmd.start) begin
            eng_go <= 1'b1; eng_op <= OP_START;
            st <= S_ADDR;
          end else if (tx_cmd.rd) begin
            cnt <= tx_cmd.val;
            if (tx_cmd.val == 8'd0) begin
              if (tx_cmd.stop) begin
                eng_go <= 1'b1; eng_op <= OP_STOP; st <= S_STOP;
              end else begin
                st <= S_IDLE;
              end
            end else begin
              eng_go <= 1'b1; eng_op <= OP_READ;
              eng_ack <= (tx_cmd.val != 8'd1);
              st <= S_RD;
            end
          end else begin
            eng_go <= 1'b1; eng_op <= OP_WRITE; eng_byte <= tx_cmd.val;
            st <= S_WR;
          end
        end
        S_ADDR: if (eng_done) begin
          eng_go <= 1'b1; eng_op <= OP_WRITE; eng_byte <= cmd_q.val;
          st <= S_WR;
        end
        S_WR: if (eng_done) begin
          if (!eng_acked) begin
            eng_go <= 1'b1; eng_op <= OP_STOP; st <= S_NSTOP;
          end else if (cmd_q.stop) begin
            eng_go <= 1'b1; eng_op <= OP_STOP; st <= S_STOP;
          end else begin
            st <= S_IDLE;
          end
        end
        S_RD: if (eng_done) begin
          cnt <= cnt - 8'd1;
          if (cnt != 8'd1) begin
            eng_go <= 1'b1; eng_op <= OP_READ;
            eng_ack <= (cnt != 8'd2);
          end else if (cmd_q.stop) begin
            eng_go <= 1'b1; eng_op <= OP_STOP; st <= S_STOP;
          end else begin
            st <= S_IDLE;
          end
        end
        S_STOP:  if (eng_done) st <= S_IDLE;
        S_NSTOP: if (eng_done) st <= cmd_q.stop ? S_IDLE : S_FLUSH;
        S_FLUSH: st <= tx_empty ? S_IDLE : S_FLCHK;
        S_FLCHK: st <= tx_cmd.stop ? S_IDLE : S_FLUSH;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R7
  idle_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && !en) |=> (st == S_IDLE && !eng_go));

endmodule

// File: rtl/cmdq_i2c_master.sv
module cmdq_i2c_master
  import i2cq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int DIV_W      = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        scl_oe,
  output logic        sda_oe,
  input  logic        sda_i
);
  logic             ctl_en;
  logic [DIV_W-1:0] ctl_div;
  logic             done_f, nack_f;
  logic             rsel_rx, rx_empty_q;
  logic [31:0]      other_q;

  logic             tx_push, tx_clr, tx_pop, tx_full, tx_empty;
  logic [CMD_W-1:0] tx_rdata;
  cmd_t             tx_cmd;
  logic             rx_push, rx_clr, rx_pop, rx_full, rx_empty;
  logic [7:0]       rx_rdata;

  logic             eng_go, eng_ack, eng_done, eng_acked;
  bus_op_e          eng_op;
  logic [7:0]       eng_byte, eng_rbyte;
  logic             set_done, set_nack;
  logic             wr_ctl, wr_stat;
  logic             wdata_unused;

  assign wdata_unused = ^{reg_wdata[31:28], reg_wdata[26:22], reg_wdata[20:12], rx_full};

  assign wr_ctl  = reg_wr && (reg_addr == RA_CTRL);
  assign wr_stat = reg_wr && (reg_addr == RA_STAT);
  assign tx_push = reg_wr && (reg_addr == RA_TX);
  assign tx_clr  = wr_ctl && reg_wdata[CTL_TXCLR_BIT];
  assign rx_clr  = wr_ctl && reg_wdata[CTL_RXCLR_BIT];
  assign rx_pop  = reg_rd && (reg_addr == RA_RX);
  assign tx_cmd  = cmd_t'(tx_rdata);

  i2cq_fifo #(.W(CMD_W), .DEPTH(FIFO_DEPTH)) i_txq (
    .clk(clk), .rst(rst), .clr(tx_clr),
    .push(tx_push), .wdata(reg_wdata[CMD_W-1:0]),
    .pop(tx_pop), .rdata(tx_rdata), .full(tx_full), .empty(tx_empty)
  );

  i2cq_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) i_rxq (
    .clk(clk), .rst(rst), .clr(rx_clr),
    .push(rx_push), .wdata(eng_rbyte),
    .pop(rx_pop), .rdata(rx_rdata), .full(rx_full), .empty(rx_empty)
  );

  i2cq_seq i_seq (
    .clk(clk), .rst(rst), .en(ctl_en),
    .tx_empty(tx_empty), .tx_cmd(tx_cmd), .tx_pop(tx_pop),
    .eng_go(eng_go), .eng_op(eng_op), .eng_byte(eng_byte), .eng_ack(eng_ack),
    .eng_done(eng_done), .eng_acked(eng_acked),
    .rx_push(rx_push), .set_done(set_done), .set_nack(set_nack)
  );

  i2cq_bitctl #(.DIVW(DIV_W)) i_bit (
    .clk(clk), .rst(rst), .div(ctl_div),
    .go(eng_go), .op(eng_op), .wbyte(eng_byte), .ack_en(eng_ack),
    .sda_i(sda_i), .done(eng_done), .rbyte(eng_rbyte), .acked(eng_acked),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_en     <= 1'b0;
      ctl_div    <= '0;
      done_f     <= 1'b0;
      nack_f     <= 1'b0;
      rsel_rx    <= 1'b0;
      rx_empty_q <= 1'b1;
      other_q    <= '0;
    end else begin
      if (wr_ctl) begin
        ctl_en  <= reg_wdata[CTL_EN_BIT];
        ctl_div <= reg_wdata[DIV_W-1:0];
      end
      if (set_done)                               done_f <= 1'b1;
      else if (wr_stat && reg_wdata[STAT_DONE_BIT]) done_f <= 1'b0;
      if (set_nack)                               nack_f <= 1'b1;
      else if (wr_stat && reg_wdata[STAT_NACK_BIT]) nack_f <= 1'b0;
      if (reg_rd) begin
        rsel_rx    <= (reg_addr == RA_RX);
        rx_empty_q <= rx_empty;
        case (reg_addr)
          RA_STAT: other_q <= (32'(done_f) << STAT_DONE_BIT) | (32'(nack_f) << STAT_NACK_BIT);
          RA_CTRL: other_q <= (32'(ctl_en) << CTL_EN_BIT) | 32'(ctl_div);
          default: other_q <= '0;
        endcase
      end
    end
  end

  always_comb begin
    if (rsel_rx)
      reg_rdata = (32'(rx_empty_q) << RX_EMPTY_BIT) | (rx_empty_q ? 32'd0 : 32'(rx_rdata));
    else
      reg_rdata = other_q;
  end

  // R6
  nack_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(nack_f) |-> $past(eng_done && !eng_acked));

  // R5
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (done_f && !(wr_stat && reg_wdata[STAT_DONE_BIT])) |=> done_f);

endmodule

// File: tb/test_cmdq_i2c_master.sv
module test_cmdq_i2c_master;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        scl_oe, sda_oe;
  logic        s_drive = 1'b0;
  wire         scl_line = ~scl_oe;
  wire         sda_line = ~(sda_oe | s_drive);

  int checks = 0, errors = 0;
  bit finished = 0;
  int cyc = 0;

  cmdq_i2c_master i_cmdq_i2c_master (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_i(sda_line)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // ---------------- bus-level device model ----------------
  localparam logic [6:0] SLV = 7'h2A;
  logic ps = 1'b1, pd = 1'b1;
  int bitc = 0;
  logic [7:0] sr = '0, txb = '0;
  logic in_addr = 0, addressed = 0, stx = 0, stx_pend = 0, mack = 0;
  logic [7:0] wlog [0:63];
  logic       mack_log [0:63];
  int wcnt = 0, mcnt = 0, rd_idx = 0, starts = 0, stops = 0, nack_at = -1;
  int rise_prev = 0, gap_b1 = 0;

  function automatic logic [7:0] rpat(input int i);
    return 8'(i * 29 + 7);
  endfunction

  always @(negedge clk) begin
    if (!rst) begin
      if (ps && scl_line && pd && !sda_line) begin
        starts++; bitc = 0; in_addr = 1; stx = 0; s_drive = 0;
      end else if (ps && scl_line && !pd && sda_line) begin
        stops++; in_addr = 0; addressed = 0; stx = 0; s_drive = 0;
      end else if (!ps && scl_line) begin
        if (bitc == 1) gap_b1 = cyc - rise_prev;
        rise_prev = cyc;
        if (bitc < 8) sr = {sr[6:0], sda_line};
        else if (bitc == 8) mack = !sda_line;
        bitc++;
      end else if (ps && !scl_line) begin
        if (bitc == 8) begin
          if (stx) s_drive = 0;
          else if (in_addr) begin
            addressed = (sr[7:1] == SLV); s_drive = addressed; stx_pend = addressed && sr[0];
          end else if (addressed) begin
            wlog[wcnt] = sr; s_drive = (wcnt != nack_at); wcnt++;
          end else s_drive = 0;
        end else if (bitc == 9) begin
          bitc = 0;
          if (in_addr) begin
            in_addr = 0;
            if (stx_pend) begin stx = 1; txb = rpat(rd_idx); rd_idx++; s_drive = !txb[7]; end
            else s_drive = 0;
          end else if (stx) begin
            mack_log[mcnt] = mack; mcnt++;
            if (mack) begin txb = rpat(rd_idx); rd_idx++; s_drive = !txb[7]; end
            else begin stx = 0; s_drive = 0; end
          end else s_drive = 0;
        end else if (stx && bitc >= 1 && bitc <= 7) begin
          s_drive = !txb[7 - bitc];
        end
      end
      ps = scl_line; pd = sda_line;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rreg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic wait_done(input string req, output logic [31:0] st);
    st = 0;
    for (int i = 0; i < 20000; i++) begin
      rreg(2, st);
      if (st[27]) break;
    end
    chk({req, " completion"}, 32'(st[27]), 32'd1);
    wreg(2, st);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, st;
    int base, s0, p0, w0, m0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 0;

    // R11 reset state, R4 empty read
    chk("R11 scl released", 32'(scl_oe), 0);
    chk("R11 sda released", 32'(sda_oe), 0);
    rreg(2, d); chk("R11 status zero", d, 0);
    rreg(3, d); chk("R11 control zero", d, 0);
    rreg(1, d); chk("R4 empty read", d, 32'h100);

    wreg(3, 32'h801);

    // R1 write message
    s0 = starts; p0 = stops; w0 = wcnt;
    wreg(0, 32'h154); wreg(0, 32'h0C3); wreg(0, 32'h23C);
    wait_done("R1", st);
    chk("R5 nack clear on good write", 32'(st[21]), 0);
    chk("R1 bytes written", wcnt - w0, 2);
    chk("R1 byte0", wlog[w0], 32'hC3);
    chk("R1 byte1", wlog[w0+1], 32'h3C);
    chk("R1 one start", starts - s0, 1);
    chk("R1 one stop", stops - p0, 1);

    // R3 read sweep N=1..4, R4 format
    for (int n = 1; n <= 4; n++) begin
      base = rd_idx; m0 = mcnt;
      wreg(0, 32'h155); wreg(0, 32'h600 | n);
      wait_done("R3", st);
      for (int k = 0; k < n; k++) begin
        rreg(1, d);
        chk("R4 rx byte", d, 32'(rpat(base + k)));
        chk("R3 ack pattern", 32'(mack_log[m0 + k]), (k == n - 1) ? 0 : 1);
      end
      rreg(1, d); chk("R4 drained", d, 32'h100);
    end

    // R2 repeated START
    s0 = starts; p0 = stops; w0 = wcnt; base = rd_idx;
    wreg(0, 32'h154); wreg(0, 32'h011); wreg(0, 32'h155); wreg(0, 32'h602);
    wait_done("R2", st);
    chk("R2 two starts", starts - s0, 2);
    chk("R2 one stop", stops - p0, 1);
    chk("R2 command byte", wlog[w0], 32'h11);
    rreg(1, d); chk("R2 rx0", d, 32'(rpat(base)));
    rreg(1, d); chk("R2 rx1", d, 32'(rpat(base + 1)));

    // R6 data NACK and discard
    w0 = wcnt; p0 = stops; nack_at = wcnt;
    wreg(0, 32'h154); wreg(0, 32'h0A1); wreg(0, 32'h0A2); wreg(0, 32'h2A3);
    wreg(0, 32'h154); wreg(0, 32'h2A4);
    wait_done("R6", st);
    chk("R6 nack flag", 32'(st[21]), 1);
    wait_done("R6 next message", st);
    chk("R5 write-back cleared nack", 32'(st[21]), 0);
    nack_at = -1;
    chk("R6 bytes reaching device", wcnt - w0, 2);
    chk("R6 refused byte", wlog[w0], 32'hA1);
    chk("R6 following message", wlog[w0+1], 32'hA4);
    chk("R6 stops", stops - p0, 2);

    // R5 write 0 keeps flag, write 1 clears
    wreg(0, 32'h354);
    for (int i = 0; i < 5000; i++) begin rreg(2, d); if (d[27]) break; end
    wreg(2, 32'h0); rreg(2, d);
    chk("R5 zero write keeps", d, 32'h0800_0000);
    wreg(2, 32'h0800_0000); rreg(2, d);
    chk("R5 one write clears", d, 0);

    // R7 disabled engine, R10 command overflow
    wreg(3, 32'h001);
    s0 = starts; w0 = wcnt;
    wreg(0, 32'h154);
    for (int k = 0; k < 14; k++) wreg(0, 32'h40 + k);
    wreg(0, 32'h2F0);
    wreg(0, 32'h154); wreg(0, 32'h2EE);
    idle(400);
    chk("R7 no start while disabled", starts - s0, 0);
    rreg(3, d); chk("R7 control readback", d, 32'h001);
    wreg(3, 32'h801);
    wait_done("R10", st);
    idle(2000);
    chk("R10 queued bytes", wcnt - w0, 15);
    chk("R10 last kept word", wlog[w0+14], 32'hF0);
    chk("R10 overflow dropped", starts - s0, 1);

    // R8 command queue flush
    wreg(3, 32'h001);
    s0 = starts;
    wreg(0, 32'h154); wreg(0, 32'h255);
    wreg(3, 32'h201);
    wreg(3, 32'h801);
    idle(1000);
    chk("R8 tx flush", starts - s0, 0);

    // R10 receive overflow, R8 receive flush
    base = rd_idx;
    wreg(0, 32'h155); wreg(0, 32'h612);
    wait_done("R10 rx", st);
    for (int k = 0; k < 16; k++) begin
      rreg(1, d); chk("R10 rx kept", d, 32'(rpat(base + k)));
    end
    rreg(1, d); chk("R10 rx lost", d, 32'h100);
    wreg(0, 32'h155); wreg(0, 32'h603);
    wait_done("R8 rx", st);
    wreg(3, 32'hC01);
    rreg(1, d); chk("R8 rx flush", d, 32'h100);

    // R9 divider sweep
    foreach (d[i]) if (i < 4) begin
      int dv;
      dv = (i == 0) ? 0 : (i == 1) ? 2 : (i == 2) ? 5 : 7;
      wreg(3, 32'h800 | dv);
      wreg(0, 32'h354);
      wait_done("R9", st);
      chk("R9 scl period", gap_b1, 4 * (dv + 1));
    end

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule